// File: doc/BRIEF.md
# Region-Based Memory Protection Checker

This block sits beside a bus master and judges every access it makes against a small set of programmable address regions. Each region carries a base, a power-of-two size, an enable, and separate read and write permissions for privileged and unprivileged code, plus a no-execute mark. For every presented access (read, write or instruction fetch) the checker returns a same-cycle allow or deny decision and, on a deny, a fault kind.

A deny raises a protection fault when software has enabled that fault. Otherwise it is escalated to the general hard fault. The address of the first violation is held in a capture register with a valid flag until software clears it. All configuration goes through a write-only register port. Writes marked unprivileged are dropped.

Top module: `rgn_guard`

## Requirements
- R1: A region covers the addresses whose bits above its size equal its base; the size field k selects 2^k bytes, values below 5 act as 32 bytes, and base bits below the size are ignored.
- R2: Attribute word bits: [0] enable, [5:1] size, [6] privileged read, [7] privileged write, [8] unprivileged read, [9] unprivileged write, [10] no-execute; a read or write is allowed only if the bit for its privilege level is set. Access type encoding: 0 read, 1 write, 2 fetch (3 acts as read).
- R3: A fetch is allowed only when the read bit for its privilege level is set and no-execute is clear.
- R4: Disabled regions never match; among overlapping enabled matches the highest-numbered region alone decides.
- R5: An access that matches no enabled region is allowed for privileged code of any type and denied for unprivileged code.
- R6: `acc_allow` is high only while `acc_valid` is high and the access is permitted; a denied valid access drives `flt_kind` to 1 (protection) if the fault enable is set, else 2 (hard); otherwise `flt_kind` is 0.
- R7: A violation while no fault is held sets `flt_valid` and captures `flt_addr` at the next edge; later violations do not overwrite it while it is held.
- R8: Writing 1 to control bit 1 clears `flt_valid`; a violation in the same cycle as the clear is captured instead and leaves `flt_valid` set.
- R9: Config writes with `cfg_priv` low change no region and no control state.
- R10: After reset all regions are disabled, the fault enable is off, `flt_valid` is 0 and `flt_addr` is 0.
- R11: Register map: word 0 is control (bit 0 fault enable, bit 1 clear); region r has its base at word 2+2r and its attributes at word 3+2r. A write takes effect for accesses from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_priv | input | 1 | Config write comes from privileged code |
| cfg_addr | input | CFG_AW | Config word index |
| cfg_wdata | input | 32 | Config write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access made by privileged code |
| acc_allow | output | 1 | Access permitted |
| flt_kind | output | 2 | 0 none, 1 protection, 2 hard |
| flt_valid | output | 1 | A captured fault is held |
| flt_addr | output | 32 | Captured faulting address |

## Verification
The fault capture register and the software clear can fall in the same cycle. This is provoked by driving a privileged control write with the clear bit set while a denied access is presented. It is judged one edge later: `flt_valid` must still be set and `flt_addr` must hold the colliding address. The bench also covers each part of the clash on its own: a held fault that ignores later violations, and a clear with no violation, which must drop the flag.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

    localparam int ADDR_W   = 32;
    localparam int SIZE_W   = 5;
    localparam int MIN_LOG2 = 5;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PROT = 2'd1,
        FLT_HARD = 2'd2
    } flt_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [SIZE_W-1:0] size_log2;
        logic              en;
        logic              p_rd;
        logic              p_wr;
        logic              u_rd;
        logic              u_wr;
        logic              no_x;
    } rgn_cfg_t;

    function automatic logic addr_in_rgn(input rgn_cfg_t c, input logic [ADDR_W-1:0] a);
        logic [SIZE_W-1:0] eff;
        logic [ADDR_W-1:0] keep;
        eff  = (c.size_log2 < SIZE_W'(MIN_LOG2)) ? SIZE_W'(MIN_LOG2) : c.size_log2;
        keep = {ADDR_W{1'b1}} << eff;
        return ((a ^ c.base) & keep) == '0;
    endfunction

    function automatic logic rgn_permits(input rgn_cfg_t c, input acc_kind_e k, input logic priv);
        logic rd_ok;
        logic wr_ok;
        rd_ok = priv ? c.p_rd : c.u_rd;
        wr_ok = priv ? c.p_wr : c.u_wr;
        case (k)
            ACC_WRITE: return wr_ok;
            ACC_FETCH: return rd_ok & ~c.no_x;
            default:   return rd_ok;
        endcase
    endfunction

endpackage

// File: rtl/rgn_guard_cfg.sv
module rgn_guard_cfg
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int CFG_AW      = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic                          cfg_priv,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    output rgn_cfg_t [NUM_REGIONS-1:0]    rgn_q,
    output logic                          fault_en_q,
    output logic                          clr_req
);

    logic wr_ok;
    assign wr_ok   = cfg_we & cfg_priv;
    assign clr_req = wr_ok && (cfg_addr == '0) && cfg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rgn_q      <= '0;
            fault_en_q <= 1'b0;
        end else if (wr_ok) begin
            if (cfg_addr == '0)
                fault_en_q <= cfg_wdata[0];
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (cfg_addr == CFG_AW'(2*r + 2)) begin
                    rgn_q[r].base <= cfg_wdata;
                end
                if (cfg_addr == CFG_AW'(2*r + 3)) begin
                    rgn_q[r].en        <= cfg_wdata[0];
                    rgn_q[r].size_log2 <= cfg_wdata[5:1];
                    rgn_q[r].p_rd      <= cfg_wdata[6];
                    rgn_q[r].p_wr      <= cfg_wdata[7];
                    rgn_q[r].u_rd      <= cfg_wdata[8];
                    rgn_q[r].u_wr      <= cfg_wdata[9];
                    rgn_q[r].no_x      <= cfg_wdata[10];
                end
            end
        end
    end

    // R9
    unpriv_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_priv) |=> ($stable(rgn_q) && $stable(fault_en_q)));

endmodule

// File: rtl/rgn_guard_slot.sv
module rgn_guard_slot
    import rgn_guard_pkg::*;
(
    input  rgn_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    input  acc_kind_e         kind,
    input  logic              priv,
    output logic              hit,
    output logic              ok
);

    assign hit = cfg.en & addr_in_rgn(cfg, addr);
    assign ok  = rgn_permits(cfg, kind, priv);

endmodule

// File: rtl/rgn_guard_fault.sv
module rgn_guard_fault
    import rgn_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              viol,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              clr_req,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid <= 1'b0;
            flt_addr  <= '0;
        end else if (viol && (!flt_valid || clr_req)) begin
            flt_valid <= 1'b1;
            flt_addr  <= viol_addr;
        end else if (clr_req) begin
            flt_valid <= 1'b0;
        end
    end

    // R7
    capture_first_chk: assert property (@(posedge clk) disable iff (rst)
        (viol && !flt_valid) |=> (flt_valid && flt_addr == $past(viol_addr)));

    // R7
    hold_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !clr_req) |=> (flt_valid && $stable(flt_addr)));

    // R8
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !viol) |=> !flt_valid);

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int CFG_AW     = $clog2(2*NUM_REGIONS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic [1:0]        acc_type,
    input  logic              acc_priv,
    output logic              acc_allow,
    output logic [1:0]        flt_kind,
    output logic              flt_valid,
    output logic [31:0]       flt_addr
);

    rgn_cfg_t [NUM_REGIONS-1:0] rgn_q;
    logic                       fault_en_q;
    logic                       clr_req;
    logic [NUM_REGIONS-1:0]     hit;
    logic [NUM_REGIONS-1:0]     ok;
    acc_kind_e                  kind;
    logic                       any_hit;
    logic                       sel_ok;
    logic                       sel_nx;
    logic                       permit;
    logic                       viol;

    assign kind = acc_kind_e'(acc_type);

    rgn_guard_cfg #(
        .NUM_REGIONS (NUM_REGIONS),
        .CFG_AW      (CFG_AW)
    ) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_priv   (cfg_priv),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .rgn_q      (rgn_q),
        .fault_en_q (fault_en_q),
        .clr_req    (clr_req)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_slot
        rgn_guard_slot slot_i (
            .cfg  (rgn_q[r]),
            .addr (acc_addr),
            .kind (kind),
            .priv (acc_priv),
            .hit  (hit[r]),
            .ok   (ok[r])
        );
    end

    always_comb begin
        any_hit = 1'b0;
        sel_ok  = 1'b0;
        sel_nx  = 1'b0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hit[r]) begin
                any_hit = 1'b1;
                sel_ok  = ok[r];
                sel_nx  = rgn_q[r].no_x;
            end
        end
    end

    assign permit    = any_hit ? sel_ok : acc_priv;
    assign viol      = acc_valid & ~permit;
    assign acc_allow = acc_valid & permit;

    always_comb begin
        if (!viol)           flt_kind = FLT_NONE;
        else if (fault_en_q) flt_kind = FLT_PROT;
        else                 flt_kind = FLT_HARD;
    end

    rgn_guard_fault fault_i (
        .clk       (clk),
        .rst       (rst),
        .viol      (viol),
        .viol_addr (acc_addr),
        .clr_req   (clr_req),
        .flt_valid (flt_valid),
        .flt_addr  (flt_addr)
    );

    // R3
    nx_fetch_denied_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && kind == ACC_FETCH && any_hit && sel_nx) |-> !acc_allow);

    // R5
    background_priv_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_priv && !any_hit) |-> acc_allow);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!acc_allow && flt_kind == FLT_NONE));

    // R6
    deny_has_kind_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_allow) |-> (flt_kind != FLT_NONE));

endmodule

// File: tb/rgn_guard_tb_top.sv
module rgn_guard_tb_top;

    localparam int CFG_AW = 5;

    logic              clk = 1'b0;
    logic              rst;
    logic              cfg_we;
    logic              cfg_priv;
    logic [CFG_AW-1:0] cfg_addr;
    logic [31:0]       cfg_wdata;
    logic              acc_valid;
    logic [31:0]       acc_addr;
    logic [1:0]        acc_type;
    logic              acc_priv;
    logic              acc_allow;
    logic [1:0]        flt_kind;
    logic              flt_valid;
    logic [31:0]       flt_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rgn_guard #(.NUM_REGIONS(8)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type), .acc_priv(acc_priv),
        .acc_allow(acc_allow), .flt_kind(flt_kind), .flt_valid(flt_valid), .flt_addr(flt_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  typ;
        logic        priv;
        logic        allow;
        logic [1:0]  kind;
        logic [3:0]  req;
    } vec_t;

    // typ: 0 read, 1 write, 2 fetch; kind: 0 none, 1 protection
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0100, 2'd0, 1'b0, 1'b1, 2'd0, 4'd2},  // R2 user read
        '{32'h0000_0100, 2'd1, 1'b0, 1'b0, 2'd1, 4'd2},  // R2 user write denied
        '{32'h0000_0100, 2'd1, 1'b1, 1'b1, 2'd0, 4'd2},  // R2 priv write
        '{32'h0000_0100, 2'd2, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 fetch ok
        '{32'h0000_1010, 2'd0, 1'b0, 1'b0, 2'd1, 4'd4},  // R4 upper region wins
        '{32'h0000_1010, 2'd1, 1'b1, 1'b0, 2'd1, 4'd4},  // R4
        '{32'h0000_1010, 2'd0, 1'b1, 1'b1, 2'd0, 4'd4},  // R4
        '{32'h0000_10FF, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1 last byte
        '{32'h0000_1100, 2'd0, 1'b0, 1'b1, 2'd0, 4'd1},  // R1 just past
        '{32'h2000_0FFC, 2'd1, 1'b0, 1'b1, 2'd0, 4'd1},  // R1 base low bits ignored
        '{32'h2000_0004, 2'd2, 1'b1, 1'b0, 2'd1, 4'd3},  // R3 no-execute
        '{32'h2000_0004, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 read same region
        '{32'h2000_1000, 2'd0, 1'b0, 1'b0, 2'd1, 4'd5},  // R5 user background
        '{32'h2000_1000, 2'd2, 1'b1, 1'b1, 2'd0, 4'd5},  // R5 priv background
        '{32'h4000_0000, 2'd0, 1'b0, 1'b0, 2'd1, 4'd4},  // R4 disabled region
        '{32'h5000_001F, 2'd1, 1'b0, 1'b1, 2'd0, 4'd1},  // R1 32-byte minimum
        '{32'h5000_0020, 2'd1, 1'b0, 1'b0, 2'd1, 4'd1},  // R1
        '{32'h0000_FFFC, 2'd0, 1'b0, 1'b1, 2'd0, 4'd1},  // R1 top of 64 KiB
        '{32'h0001_0000, 2'd0, 1'b0, 1'b0, 2'd1, 4'd5},  // R5
        '{32'h0001_0000, 2'd1, 1'b1, 1'b1, 2'd0, 4'd5}   // R5
    };

    function automatic logic [31:0] attr(input bit en, input int sz, input bit pr, input bit pw,
                                         input bit ur, input bit uw, input bit nx);
        return {21'd0, nx, uw, ur, pw, pr, 5'(sz), en};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input logic [31:0] d, input bit p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = p; cfg_addr = CFG_AW'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(input logic [31:0] a, input logic [1:0] t, input bit p);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_type = t; acc_priv = p;
        #5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_priv = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        acc_valid = 1'b0; acc_addr = '0; acc_type = '0; acc_priv = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // R10 reset state
        check("R10 flt_valid", 32'(flt_valid), 32'd0);
        check("R10 flt_addr", flt_addr, 32'd0);
        check("R6 idle allow", 32'(acc_allow), 32'd0);
        check("R6 idle kind", 32'(flt_kind), 32'd0);
        // R10 no regions, faults off: user denied as hard, priv allowed
        drive(32'h100, 2'd0, 1'b0);
        check("R10 user kind hard", 32'(flt_kind), 32'd2);
        check("R10 user allow", 32'(acc_allow), 32'd0);
        drive(32'h100, 2'd0, 1'b1);
        check("R5 priv allow", 32'(acc_allow), 32'd1);
        check("R7 hard fault captured", {31'd0, flt_valid}, 32'd1);
        check("R7 hard fault addr", flt_addr, 32'h100);
        @(negedge clk); acc_valid = 1'b0;

        // R11 configuration
        cfg_wr(0, 32'd3, 1'b1);
        check("R8 clear", 32'(flt_valid), 32'd0);
        cfg_wr(2, 32'h0000_0000, 1'b1); cfg_wr(3, attr(1, 16, 1, 1, 1, 0, 0), 1'b1);
        cfg_wr(4, 32'h2000_0123, 1'b1); cfg_wr(5, attr(1, 12, 1, 1, 1, 1, 1), 1'b1);
        cfg_wr(6, 32'h0000_1000, 1'b1); cfg_wr(7, attr(1, 8, 1, 0, 0, 0, 0), 1'b1);
        cfg_wr(8, 32'h4000_0000, 1'b1); cfg_wr(9, attr(0, 5, 1, 1, 1, 1, 0), 1'b1);
        cfg_wr(10, 32'h5000_0000, 1'b1); cfg_wr(11, attr(1, 2, 1, 1, 1, 1, 0), 1'b1);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].addr, VECS[i].typ, VECS[i].priv);
            check($sformatf("R%0d vec%0d allow", VECS[i].req, i), 32'(acc_allow), 32'(VECS[i].allow));
            check($sformatf("R%0d vec%0d kind", VECS[i].req, i), 32'(flt_kind), 32'(VECS[i].kind));
        end
        @(negedge clk); acc_valid = 1'b0;
        // R7 first violation of the table (vector 1) still held
        check("R7 held valid", 32'(flt_valid), 32'd1);
        check("R7 held addr", flt_addr, 32'h100);

        cfg_wr(0, 32'd3, 1'b1);
        check("R8 clear alone", 32'(flt_valid), 32'd0);

        // R9 unprivileged writes dropped
        cfg_wr(3, attr(1, 16, 1, 1, 1, 1, 0), 1'b0);
        cfg_wr(0, 32'd0, 1'b0);
        drive(32'h100, 2'd1, 1'b0);
        check("R9 attr unchanged", 32'(acc_allow), 32'd0);
        check("R9 fault enable unchanged", 32'(flt_kind), 32'd1);
        @(negedge clk); acc_valid = 1'b0;
        cfg_wr(0, 32'd3, 1'b1);

        // R7 capture then hold
        drive(32'h0000_1010, 2'd0, 1'b0);
        drive(32'h2000_1000, 2'd0, 1'b0);
        check("R7 captured valid", 32'(flt_valid), 32'd1);
        check("R7 captured addr", flt_addr, 32'h0000_1010);
        @(negedge clk); acc_valid = 1'b0;
        #5;
        check("R7 not overwritten", flt_addr, 32'h0000_1010);

        // R8 clear colliding with a violation
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b1; cfg_addr = '0; cfg_wdata = 32'd3;
        acc_valid = 1'b1; acc_addr = 32'h5000_0020; acc_type = 2'd1; acc_priv = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
        #5;
        check("R8 collision valid", 32'(flt_valid), 32'd1);
        check("R8 collision addr", flt_addr, 32'h5000_0020);
        cfg_wr(0, 32'd3, 1'b1);
        check("R8 clear after collision", 32'(flt_valid), 32'd0);

        // R6 deny address without valid: no fault, no capture
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h2000_1000; acc_type = 2'd0; acc_priv = 1'b0;
        #5;
        check("R6 no valid kind", 32'(flt_kind), 32'd0);
        check("R6 no valid allow", 32'(acc_allow), 32'd0);
        @(negedge clk); #5;
        check("R6 no valid no capture", 32'(flt_valid), 32'd0);

        // R6 fault enable off escalates to hard
        cfg_wr(0, 32'd0, 1'b1);
        drive(32'h100, 2'd1, 1'b0);
        check("R6 escalate kind", 32'(flt_kind), 32'd2);
        check("R6 escalate allow", 32'(acc_allow), 32'd0);
        @(negedge clk); acc_valid = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule